// File: doc/BRIEF.md
# Three-Register Branching Datapath Sequencer

This block is a small finite-state machine with datapath that works on three W-bit registers, named A, B and C, under a six-state control variable. The sequencer waits in a terminal state until it sees a start pulse. On that pulse it takes B and C from two seed inputs and clears A. It then walks a fixed branching program. In each state it performs exactly one register assignment, which is an add, a bitwise inversion, or an inversion followed by an add. Three condition inputs decide which branch is taken, and every branch ends in the same terminal state.

A surrounding controller drives the seeds and the start pulse, steers the branches with the condition inputs, and reads the three registers once done rises again. The condition inputs are sampled anew in every cycle, so a branch decision depends only on the values present in the cycle that the relevant state is active.

Top module: `cond_fsmd`

## Requirements
- R1: After reset, done is 1 and reg_a, reg_b and reg_c are all 0. The sequencer sits in the terminal state (state 5).
- R2: With the sequencer in the terminal state, a clock edge with start=1 loads reg_b from seed_b and reg_c from seed_c and clears reg_a. The next state is 0, and done reads 0 after that edge.
- R3: In state 0, A becomes B+C and the next state is 1.
- R4: In state 1 with cond_a=0, A becomes (~A)+1 and the next state is 4. With cond_a=1, B becomes B+C and the next state is 2.
- R5: In state 2 with cond_b=0, C becomes A+B and the next state is 5. With cond_b=1, C becomes ~C and the next state is 3.
- R6: In state 3 with cond_c=0, C becomes A+B. With cond_c=1, A becomes (~C)+B. Both branches go to state 5.
- R7: In state 4, cond_c=1 makes C become ~C regardless of cond_a. With cond_c=0 and cond_a=0, A becomes A+(~B)+C+1. With cond_c=0 and cond_a=1, no register changes. Every case goes to state 5.
- R8: Outside the terminal state, start, seed_b and seed_c have no effect. In the terminal state without start, all three registers hold their values and done stays 1.
- R9: All arithmetic wraps modulo 2^W. For example, with W=8, B=0xC8 and C=0x64, state 0 gives A=0x2C.
- R10: Counting the edge that samples start as the first, done is 1 after the 4th clock edge on paths that leave through state 2 or state 4, and after the 5th edge on paths through state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only in the terminal state |
| cond_a | input | 1 | Branch condition used in states 1 and 4 |
| cond_b | input | 1 | Branch condition used in state 2 |
| cond_c | input | 1 | Branch condition used in states 3 and 4 |
| seed_b | input | W | Value loaded into B on start |
| seed_c | input | W | Value loaded into C on start |
| reg_a | output | W | Register A |
| reg_b | output | W | Register B |
| reg_c | output | W | Register C |
| done | output | 1 | Sequencer is in the terminal state |

## Verification
The hardest case to reach is the quiet branch of state 4, where cond_a=1 and cond_c=0. State 4 can only be entered when cond_a was 0 one cycle earlier, so this branch is unreachable if the conditions are held steady for a whole run. To reach it, the bench draws fresh random conditions in every cycle and also runs a directed sequence that drops cond_a in state 1 and raises it in state 4. A bench-side model steps in lockstep with the design and checks all three registers and done after every edge. During these runs, start and both seeds are toggled while the sequencer is busy, to show that they are ignored.

// File: rtl/cond_fsmd_pkg.sv
package cond_fsmd_pkg;
  typedef enum logic [2:0] {
    ST_S0 = 3'd0, ST_S1 = 3'd1, ST_S2 = 3'd2,
    ST_S3 = 3'd3, ST_S4 = 3'd4, ST_S5 = 3'd5
  } state_t;

  typedef enum logic [3:0] {
    OP_HOLD, OP_LOAD, OP_A_SUM_BC, OP_A_NEG, OP_B_ACC,
    OP_C_SUM_AB, OP_C_INV, OP_A_INVC_B, OP_A_DIFF
  } op_t;
endpackage

// File: rtl/cond_fsmd_ctrl.sv
module cond_fsmd_ctrl
  import cond_fsmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cond_a,
  input  logic cond_b,
  input  logic cond_c,
  output op_t  op,
  output logic done
);
  state_t q, q_nx;

  always_comb begin
    q_nx = q;
    op   = OP_HOLD;
    unique case (q)
      ST_S0: begin op = OP_A_SUM_BC; q_nx = ST_S1; end
      ST_S1: begin
        if (!cond_a) begin op = OP_A_NEG; q_nx = ST_S4; end
        else         begin op = OP_B_ACC; q_nx = ST_S2; end
      end
      ST_S2: begin
        if (!cond_b) begin op = OP_C_SUM_AB; q_nx = ST_S5; end
        else         begin op = OP_C_INV;    q_nx = ST_S3; end
      end
      ST_S3: begin
        op   = cond_c ? OP_A_INVC_B : OP_C_SUM_AB;
        q_nx = ST_S5;
      end
      ST_S4: begin
        if (cond_c)       op = OP_C_INV;
        else if (!cond_a) op = OP_A_DIFF;
        else              op = OP_HOLD;
        q_nx = ST_S5;
      end
      ST_S5: begin
        if (start) begin op = OP_LOAD; q_nx = ST_S0; end
      end
      default: q_nx = ST_S5;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= ST_S5;
      done <= 1'b1;
    end else begin
      q    <= q_nx;
      done <= (q_nx == ST_S5);
    end
  end

  p_start_leaves_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (q == ST_S5 && start) |=> (q == ST_S0 && !done));
  p_s0_to_s1_r3: assert property (@(posedge clk) disable iff (rst)
    (q == ST_S0) |=> (q == ST_S1));
  p_s3_ends_r6: assert property (@(posedge clk) disable iff (rst)
    (q == ST_S3) |=> (q == ST_S5 && done));
  p_s4_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (q == ST_S4) |=> (q == ST_S5 && done));
  p_idle_stays_r8: assert property (@(posedge clk) disable iff (rst)
    (q == ST_S5 && !start) |=> (q == ST_S5 && done));
endmodule

// File: rtl/cond_fsmd_dp.sv
module cond_fsmd_dp
  import cond_fsmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  op_t          op,
  input  logic [W-1:0] seed_b,
  input  logic [W-1:0] seed_c,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] c_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:     begin a_q <= '0; b_q <= seed_b; c_q <= seed_c; end
        OP_A_SUM_BC: a_q <= b_q + c_q;
        OP_A_NEG:    a_q <= ~a_q + ONE;
        OP_B_ACC:    b_q <= b_q + c_q;
        OP_C_SUM_AB: c_q <= a_q + b_q;
        OP_C_INV:    c_q <= ~c_q;
        OP_A_INVC_B: a_q <= ~c_q + b_q;
        OP_A_DIFF:   a_q <= a_q + ~b_q + c_q + ONE;
        default:     ;
      endcase
    end
  end

  p_neg_sums_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_A_NEG) |=> ((a_q + $past(a_q)) == '0));
  p_c_inv_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_C_INV) |=> ((c_q ^ $past(c_q)) == '1 && $stable(a_q) && $stable(b_q)));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)));
endmodule

// File: rtl/cond_fsmd.sv
module cond_fsmd
  import cond_fsmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         cond_a,
  input  logic         cond_b,
  input  logic         cond_c,
  input  logic [W-1:0] seed_b,
  input  logic [W-1:0] seed_c,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic [W-1:0] reg_c,
  output logic         done
);
  op_t op;

  cond_fsmd_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .cond_a(cond_a), .cond_b(cond_b), .cond_c(cond_c),
    .op(op), .done(done)
  );

  cond_fsmd_dp #(.W(W)) dp_i (
    .clk(clk), .rst(rst), .op(op),
    .seed_b(seed_b), .seed_c(seed_c),
    .a_q(reg_a), .b_q(reg_b), .c_q(reg_c)
  );
endmodule

// File: tb/cond_fsmd_tb_top.sv
`timescale 1ns/1ps
module cond_fsmd_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cond_a = 1'b0, cond_b = 1'b0, cond_c = 1'b0;
  logic [W-1:0] seed_b = '0, seed_c = '0;
  logic [W-1:0] reg_a, reg_b, reg_c;
  logic done;

  int checks = 0;
  int errors = 0;
  int seed = 32'h5A17;

  int mst;
  logic [W-1:0] ma, mb, mc;

  always #2.5 clk = ~clk;

  cond_fsmd #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .cond_a(cond_a), .cond_b(cond_b), .cond_c(cond_c),
    .seed_b(seed_b), .seed_c(seed_c),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .done(done)
  );

  task automatic check_all(input string tag);
    checks++;
    if (reg_a !== ma || reg_b !== mb || reg_c !== mc || done !== (mst == 5)) begin
      errors++;
      $display("FAIL %s: got a=%h b=%h c=%h done=%b, expected a=%h b=%h c=%h done=%b",
               tag, reg_a, reg_b, reg_c, done, ma, mb, mc, (mst == 5));
    end
  endtask

  function automatic string tag_of(input int st, input logic x_a, input logic x_c);
    case (st)
      0: return ((int'(mb) + int'(mc)) > 255) ? "R9" : "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return (x_a && !x_c) ? "R7 quiet" : "R7";
      default: return "R8";
    endcase
  endfunction

  // one model step for the state that was active before the edge
  task automatic model_step(input logic x_a, input logic x_b, input logic x_c);
    case (mst)
      0: begin ma = mb + mc; mst = 1; end
      1: if (!x_a) begin ma = -ma; mst = 4; end
         else begin mb = mb + mc; mst = 2; end
      2: if (!x_b) begin mc = ma + mb; mst = 5; end
         else begin mc = ~mc; mst = 3; end
      3: begin
           if (!x_c) mc = ma + mb; else ma = mb - mc - 8'd1;
           mst = 5;
         end
      4: begin
           if (x_c) mc = ~mc; else if (!x_a) ma = ma - mb + mc;
           mst = 5;
         end
      default: ;
    endcase
  endtask

  // mode 0: random per cycle, 1: quiet state-4 branch, 2: long path via state 3
  task automatic run_one(input logic [W-1:0] sb, input logic [W-1:0] sc, input int mode);
    int edges;
    int exp_lat;
    logic [2:0] cv;
    @(negedge clk);
    seed_b = sb; seed_c = sc; start = 1'b1;
    cond_a = 1'($urandom); cond_b = 1'($urandom); cond_c = 1'($urandom);
    @(posedge clk);
    ma = '0; mb = sb; mc = sc; mst = 0; edges = 1; exp_lat = 4;
    @(negedge clk);
    check_all("R2");
    while (mst != 5 && edges < 10) begin
      cv = 3'($urandom);
      if (mode == 1) cv = (mst == 4) ? 3'b001 : 3'b000;
      if (mode == 2) cv = 3'b111;
      cond_a = cv[0]; cond_b = cv[1]; cond_c = cv[2];
      start  = 1'($urandom);
      seed_b = 8'($urandom); seed_c = 8'($urandom);
      if (mst == 3) exp_lat = 5;
      begin
        string t;
        t = tag_of(mst, cv[0], cv[2]);
        @(posedge clk);
        model_step(cv[0], cv[1], cv[2]);
        edges++;
        @(negedge clk);
        check_all(t);
      end
    end
    start = 1'b0;
    checks++;
    if (edges != exp_lat || done !== 1'b1) begin
      errors++;
      $display("FAIL R10: latency %0d done=%b, expected %0d done=1", edges, done, exp_lat);
    end
    // idle: seeds change without start, nothing moves (R8)
    seed_b = 8'($urandom); seed_c = 8'($urandom);
    @(posedge clk);
    @(negedge clk);
    check_all("R8 idle");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    mst = 5; ma = '0; mb = '0; mc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");
    @(negedge clk);
    check_all("R1 after reset");
    run_one(8'hC8, 8'h64, 0);   // wrap R9
    run_one(8'h10, 8'h05, 1);   // state 4 quiet branch R7
    run_one(8'hFF, 8'h01, 2);   // long path R6, R10
    run_one(8'h00, 8'h00, 1);
    run_one(8'h80, 8'h80, 2);
    for (int i = 0; i < 300; i++) run_one(8'($urandom), 8'($urandom), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule